// File: doc/BRIEF.md
# ADC Conversion Cycle Controller

This block sequences a low-power sampling converter through a fixed cycle: a power-on hold, a timed conversion, a low-power wait with the result frozen in a holding register, and a data phase during which a serial interface reads that result out. It drives enables for the converter core and for the voltage reference. The cycle restarts only when a readout finishes, so every result is read exactly once and no free-running timer is involved.

After a conversion the converter core always powers down. The reference stays on (nap) unless a sleep request was made during the preceding data phase, in which case it powers down as well (sleep) until the next acknowledged access. The raw signed result is clamped into an unsigned output code. A flag marks results taken while the reference was still settling, which always includes the first conversion after power-up. All durations are parameters given in system clock cycles.

Top module: `adc_cycle_ctrl`

## Requirements
- R1: While `supply_ok_i` is low, `phase_o` is 0, both enables are 0, and `code_o` and `code_bad_o` are 0. After `supply_ok_i` rises, the phase stays 0 for exactly POR_CYC clock edges and then becomes 1.
- R2: A conversion (`phase_o` = 1) lasts exactly CONV_CYC clocks with `conv_en_o` = 1 and `ref_en_o` = 1, and then the phase becomes 2.
- R3: Access acknowledges, read-done and stop pulses during a conversion neither shorten nor end it. Only a low supply ends it early, forcing phase 0 at once.
- R4: At the end of a conversion `code_o` loads `raw_i` clamped to the output range. With DIFF=1 the code is raw+2^(OUT_W-1), limited to 0..2^OUT_W-1 (raw 0 gives 32768 for OUT_W=16). With DIFF=0 the code is raw itself, limited to the same range.
- R5: `code_o` changes only at the end of a conversion (or on a low supply). It stays fixed through the wait and data phases whatever `raw_i` does.
- R6: In the wait phase (`phase_o` = 2) `conv_en_o` is 0, and the block stays there, ignoring read-done and stop, until `acc_ack_i` is seen.
- R7: `acc_ack_i` in the wait phase moves the block to the data phase (`phase_o` = 3) on the next clock, with `ref_en_o` = 1.
- R8: In the data phase, `rd_done_i` or `stop_i` starts a new conversion on the next clock.
- R9: A `sleep_req_i` pulse in the data phase makes the next wait phase a sleep phase with `ref_en_o` = 0. The request is consumed on entering that wait phase, so a later wait phase without a fresh request keeps `ref_en_o` = 1.
- R10: `code_bad_o` is set with a result whose conversion began before the reference had been on for REF_CYC consecutive clocks, and cleared otherwise. The first result after power-up is always marked bad.
- R11: `phase_o` encoding: 0 power-on hold, 1 converting, 2 waiting, 3 data transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| supply_ok_i | input | 1 | Supply above threshold; low acts as asynchronous power-on reset |
| raw_i | input | RAW_W | Signed raw result from the decimator |
| sleep_req_i | input | 1 | Request full power-down after the next conversion |
| acc_ack_i | input | 1 | Serial interface acknowledged an access |
| rd_done_i | input | 1 | All result bits have been shifted out |
| stop_i | input | 1 | Access ended by a bus stop |
| phase_o | output | 2 | Current phase (see R11) |
| conv_en_o | output | 1 | Converter core power enable |
| ref_en_o | output | 1 | Reference power enable |
| code_o | output | OUT_W | Held unsigned result code |
| code_bad_o | output | 1 | Held result taken with an unsettled reference |

## Verification
The clamp is exercised with raw values at zero, in the middle of the range, at both exact full-scale edges and beyond each edge. These values separate a correct bias-and-saturate from a wrap-around or an off-by-one limit. The cycle is driven with readouts ended by read-done and by stop, with stray handshakes injected mid-conversion and during the wait, and with a supply drop mid-conversion. These runs tell a fixed conversion length apart from one that can be aborted. A short versus long dwell before readout, combined with and without a sleep request, distinguishes the settle-flag and nap-versus-sleep decisions.

// File: rtl/adc_cycle_pkg.sv
package adc_cycle_pkg;
   typedef enum logic [1:0] {
      PH_POR  = 2'd0,
      PH_CONV = 2'd1,
      PH_WAIT = 2'd2,
      PH_XFER = 2'd3
   } phase_t;
endpackage

// File: rtl/adc_cyc_timer.sv
// Shared cycle timer for the power-on hold and the conversion.
module adc_cyc_timer #(
   parameter int CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          en_i,
   input  logic [CW-1:0] lim_i,
   output logic          done_o
);
   logic [CW-1:0] cnt_q;

   assign done_o = en_i && (cnt_q == lim_i - CW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (done_o) cnt_q <= '0;
      else if (en_i)   cnt_q <= cnt_q + CW'(1);
   end

   // R2: the count never runs past its limit
   p_cnt_below_lim_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> (cnt_q < lim_i));
endmodule

// File: rtl/adc_ref_settle.sv
// Tracks how long the reference has been continuously powered.
module adc_ref_settle #(
   parameter int REF_CYC = 12000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic on_i,
   output logic ready_o
);
   localparam int RW = $clog2(REF_CYC + 1);
   logic [RW-1:0] cnt_q;

   assign ready_o = (cnt_q == RW'(REF_CYC));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (!on_i)    cnt_q <= '0;
      else if (!ready_o) cnt_q <= cnt_q + RW'(1);
   end

   // R10: switching the reference off discards the settle progress
   p_off_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !on_i |=> !ready_o);
endmodule

// File: rtl/adc_code_hold.sv
// Clamps the raw result into the code range and holds it.
module adc_code_hold #(
   parameter int RAW_W = 18,
   parameter int OUT_W = 16,
   parameter bit DIFF  = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    load_i,
   input  logic signed [RAW_W-1:0] raw_i,
   output logic [OUT_W-1:0]        code_o
);
   localparam int SW = RAW_W + 1;
   localparam logic signed [SW-1:0] TOPV = SW'((2 ** OUT_W) - 1);

   logic signed [SW-1:0] ext, biased;
   logic [OUT_W-1:0]     clamped;

   assign ext = {raw_i[RAW_W-1], raw_i};

   generate
      if (DIFF) begin : g_diff
         assign biased = ext + SW'(2 ** (OUT_W - 1));
      end else begin : g_single
         assign biased = ext;
      end
   endgenerate

   always_comb begin
      if (biased < 0)         clamped = '0;
      else if (biased > TOPV) clamped = '1;
      else                    clamped = biased[OUT_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     code_o <= '0;
      else if (load_i) code_o <= clamped;
   end

   // R5: the held code moves only on a load
   p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(code_o));
endmodule

// File: rtl/adc_cycle_ctrl.sv
module adc_cycle_ctrl
   import adc_cycle_pkg::*;
#(
   parameter int RAW_W    = 18,
   parameter int OUT_W    = 16,
   parameter bit DIFF     = 1'b1,
   parameter int POR_CYC  = 500,
   parameter int CONV_CYC = 16600,
   parameter int REF_CYC  = 12000
) (
   input  logic                    clk_i,
   input  logic                    supply_ok_i,
   input  logic signed [RAW_W-1:0] raw_i,
   input  logic                    sleep_req_i,
   input  logic                    acc_ack_i,
   input  logic                    rd_done_i,
   input  logic                    stop_i,
   output logic [1:0]              phase_o,
   output logic                    conv_en_o,
   output logic                    ref_en_o,
   output logic [OUT_W-1:0]        code_o,
   output logic                    code_bad_o
);
   localparam int MAXC = (POR_CYC > CONV_CYC) ? POR_CYC : CONV_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   if (POR_CYC < 2 || CONV_CYC < 2 || REF_CYC < 1) begin : g_bad_cyc
      $error("adc_cycle_ctrl: cycle parameters out of range");
   end
   if (RAW_W <= OUT_W || OUT_W < 2) begin : g_bad_width
      $error("adc_cycle_ctrl: RAW_W must exceed OUT_W");
   end

   phase_t  phase_q;
   logic    sleep_pend_q, sleep_mode_q, bad_start_q, code_bad_q;
   logic    tmr_en, tmr_done, ref_ready, load_code;
   logic [CW-1:0] tmr_lim;

   assign tmr_en    = (phase_q == PH_POR) || (phase_q == PH_CONV);
   assign tmr_lim   = (phase_q == PH_POR) ? CW'(POR_CYC) : CW'(CONV_CYC);
   assign load_code = (phase_q == PH_CONV) && tmr_done;

   assign phase_o    = phase_q;
   assign conv_en_o  = (phase_q == PH_CONV);
   assign ref_en_o   = (phase_q == PH_CONV) || (phase_q == PH_XFER) ||
                       ((phase_q == PH_WAIT) && !sleep_mode_q);
   assign code_bad_o = code_bad_q;

   adc_cyc_timer #(.CW(CW)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (supply_ok_i),
      .en_i   (tmr_en),
      .lim_i  (tmr_lim),
      .done_o (tmr_done)
   );

   adc_ref_settle #(.REF_CYC(REF_CYC)) u_settle (
      .clk_i   (clk_i),
      .rst_ni  (supply_ok_i),
      .on_i    (ref_en_o),
      .ready_o (ref_ready)
   );

   adc_code_hold #(.RAW_W(RAW_W), .OUT_W(OUT_W), .DIFF(DIFF)) u_hold (
      .clk_i  (clk_i),
      .rst_ni (supply_ok_i),
      .load_i (load_code),
      .raw_i  (raw_i),
      .code_o (code_o)
   );

   always_ff @(posedge clk_i or negedge supply_ok_i) begin
      if (!supply_ok_i) begin
         phase_q      <= PH_POR;
         sleep_pend_q <= 1'b0;
         sleep_mode_q <= 1'b0;
         bad_start_q  <= 1'b0;
         code_bad_q   <= 1'b0;
      end else begin
         case (phase_q)
            PH_POR: if (tmr_done) begin
               phase_q     <= PH_CONV;
               bad_start_q <= !ref_ready;
            end
            PH_CONV: if (tmr_done) begin
               phase_q      <= PH_WAIT;
               sleep_mode_q <= sleep_pend_q;
               sleep_pend_q <= 1'b0;
               code_bad_q   <= bad_start_q;
            end
            PH_WAIT: if (acc_ack_i) begin
               phase_q      <= PH_XFER;
               sleep_mode_q <= 1'b0;
            end
            PH_XFER: begin
               if (sleep_req_i) sleep_pend_q <= 1'b1;
               if (rd_done_i || stop_i) begin
                  phase_q     <= PH_CONV;
                  bad_start_q <= !ref_ready;
               end
            end
            default: phase_q <= PH_POR;
         endcase
      end
   end

   // R1: power-on hold hands over to a conversion
   p_por_to_conv_r1: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (phase_q == PH_POR && tmr_done) |=> (phase_q == PH_CONV));
   // R3: a running conversion is not left before its timer expires
   p_no_abort_r3: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (phase_q == PH_CONV && !tmr_done) |=> (phase_q == PH_CONV));
   // R6: wait is held until an acknowledge
   p_wait_idle_r6: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (phase_q == PH_WAIT && !acc_ack_i) |=> (phase_q == PH_WAIT));
   // R7: acknowledge opens the data phase with the reference on
   p_ack_to_xfer_r7: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (phase_q == PH_WAIT && acc_ack_i) |=> (phase_q == PH_XFER && ref_en_o));
   // R8: end of access restarts conversion
   p_end_to_conv_r8: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (phase_q == PH_XFER && (rd_done_i || stop_i)) |=> (phase_q == PH_CONV));
   // R9: a pending sleep request turns the reference off in the wait phase
   p_sleep_ref_off_r9: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      (load_code && sleep_pend_q) |=> (!ref_en_o && !sleep_pend_q));
endmodule

// File: tb/adc_cycle_ctrl_test.sv
module adc_cycle_ctrl_test;
   localparam int RAW_W = 18;
   localparam int OUT_W = 16;
   localparam int PORC  = 5;
   localparam int CONVC = 20;
   localparam int REFC  = 30;

   logic clk = 1'b0;
   logic supply_ok = 1'b0;
   logic signed [RAW_W-1:0] raw = '0;
   logic sleep_req = 1'b0, acc_ack = 1'b0, rd_done = 1'b0, stop = 1'b0;
   logic [1:0] phase;
   logic conv_en, ref_en, code_bad;
   logic [OUT_W-1:0] code;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   adc_cycle_ctrl #(.RAW_W(RAW_W), .OUT_W(OUT_W), .DIFF(1'b1), .POR_CYC(PORC),
                    .CONV_CYC(CONVC), .REF_CYC(REFC)) uut (
      .clk_i(clk), .supply_ok_i(supply_ok), .raw_i(raw), .sleep_req_i(sleep_req),
      .acc_ack_i(acc_ack), .rd_done_i(rd_done), .stop_i(stop),
      .phase_o(phase), .conv_en_o(conv_en), .ref_en_o(ref_en),
      .code_o(code), .code_bad_o(code_bad));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic stay_count(input logic [1:0] ph, output int n);
      n = 0;
      while (phase == ph && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic pulse_ack();
      acc_ack = 1'b1;
      @(negedge clk);
      acc_ack = 1'b0;
   endtask

   task automatic finish_access(input bit use_stop);
      if (use_stop) stop = 1'b1; else rd_done = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      rd_done = 1'b0;
   endtask

   // one read-and-convert cycle starting from the wait phase
   task automatic run_cycle(input int rawv, input bit use_stop);
      int n;
      pulse_ack();
      raw = RAW_W'(rawv);
      finish_access(use_stop);
      stay_count(2'd1, n);
   endtask

   task automatic t_power_on();
      int n;
      supply_ok = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 phase in reset", phase, 0);
      check("R1 conv_en in reset", conv_en, 0);
      check("R1 ref_en in reset", ref_en, 0);
      check("R1 code in reset", code, 0);
      check("R1 bad flag in reset", code_bad, 0);
      supply_ok = 1'b1;
      stay_count(2'd0, n);
      check("R1 power-on hold length", n, PORC);
      check("R11 phase after hold", phase, 1);
      check("R2 conv_en converting", conv_en, 1);
      check("R2 ref_en converting", ref_en, 1);
      stay_count(2'd1, n);
      check("R2 first conversion length", n, CONVC);
      check("R11 phase after conversion", phase, 2);
      check("R4 raw 0 gives mid-scale", code, 32768);
      check("R10 first result marked bad", code_bad, 1);
      check("R6 conv_en off in wait", conv_en, 0);
      check("R9 nap keeps reference", ref_en, 1);
   endtask

   task automatic t_hold_wait();
      raw = RAW_W'(1234);
      repeat (10) @(negedge clk);
      finish_access(1'b0);
      finish_access(1'b1);
      repeat (30) @(negedge clk);
      check("R6 wait ignores read-done and stop", phase, 2);
      check("R5 code frozen in wait", code, 32768);
      pulse_ack();
      check("R7 ack opens data phase", phase, 3);
      check("R7 reference on in data phase", ref_en, 1);
      repeat (3) @(negedge clk);
      check("R5 code frozen in data phase", code, 32768);
   endtask

   task automatic t_no_abort();
      int n;
      finish_access(1'b0);
      check("R8 read-done starts conversion", phase, 1);
      n = 0;
      repeat (4) begin @(negedge clk); n++; end
      acc_ack = 1'b1; rd_done = 1'b1; stop = 1'b1;
      @(negedge clk); n++;
      acc_ack = 1'b0; rd_done = 1'b0; stop = 1'b0;
      while (phase == 2'd1 && n < 1000) begin @(negedge clk); n++; end
      check("R3 conversion length with stray pulses", n, CONVC);
      check("R4 raw 1234 code", code, 34002);
      check("R10 settled result not bad", code_bad, 0);
   endtask

   task automatic t_clamp();
      run_cycle(40000, 1'b1);
      check("R4 above full scale clamps high", code, 65535);
      check("R8 stop ended access", phase, 2);
      run_cycle(-40000, 1'b0);
      check("R4 below full scale clamps low", code, 0);
      run_cycle(32767, 1'b1);
      check("R4 top edge", code, 65535);
      run_cycle(-32768, 1'b0);
      check("R4 bottom edge", code, 0);
      run_cycle(-1, 1'b0);
      check("R4 minus one", code, 32767);
   endtask

   task automatic t_sleep();
      int n;
      pulse_ack();
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      raw = RAW_W'(100);
      finish_access(1'b0);
      stay_count(2'd1, n);
      check("R9 sleep wait phase", phase, 2);
      check("R9 sleep turns reference off", ref_en, 0);
      check("R6 conv_en off in sleep", conv_en, 0);
      repeat (5) @(negedge clk);
      pulse_ack();
      check("R7 ack restores reference", ref_en, 1);
      raw = RAW_W'(200);
      finish_access(1'b0);
      stay_count(2'd1, n);
      check("R10 unsettled start marked bad", code_bad, 1);
      check("R4 code after sleep", code, 32968);
      check("R9 request consumed, nap next", ref_en, 1);
   endtask

   task automatic t_supply_drop();
      int n;
      pulse_ack();
      finish_access(1'b0);
      repeat (5) @(negedge clk);
      supply_ok = 1'b0;
      #1;
      check("R3 supply drop aborts conversion", phase, 0);
      check("R1 code cleared by supply drop", code, 0);
      check("R1 bad flag cleared by supply drop", code_bad, 0);
      check("R1 conv_en off after drop", conv_en, 0);
      @(negedge clk);
      supply_ok = 1'b1;
      stay_count(2'd0, n);
      check("R1 hold length after drop", n, PORC);
   endtask

   initial begin
      t_power_on();
      t_hold_wait();
      t_no_abort();
      t_clamp();
      t_sleep();
      t_supply_drop();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule